// File: doc/BRIEF.md
# Dual-Bus Registered Transceiver

This block links two 16-bit ports, A and B, split into two independent 8-bit lanes. Each lane can move data from A to B or from B to A. The driven port receives either the live value on the opposite port or the value held in a storage register for that direction. Every lane has its own direction, active-low enable, two source selects and two capture strobes. Tying the two lanes' controls together gives plain 16-bit operation.

Each port is modelled as three vectors instead of tri-state pins:
- an input vector,
- an output value vector,
- a per-bit output-enable vector.

Enable low means the bit is released. While a bit is released, its output value reads zero.

The capture strobes are sampled on the system clock `clk`. A rising edge on a strobe is seen as high now and low at the previous `clk` edge. On that `clk` edge the register loads the opposite port's input. All output paths are combinational, so a change on a control or data input shows at the ports in the same cycle.

Top module: `dual_bus_xcvr`

## Requirements
- R1: With a lane's `oe_n` low and `dir_ab` high, that lane's `b_oe` bits are all 1. Its `a_oe` and `a_out` bits are all 0.
- R2: With a lane's `oe_n` low and `dir_ab` low, that lane's `a_oe` bits are all 1. Its `b_oe` and `b_out` bits are all 0.
- R3: With a lane's `oe_n` high, all `a_oe`, `b_oe`, `a_out` and `b_out` bits of that lane are 0.
- R4: With the select for the active direction low, the driven port shows the opposite port's input unchanged and not inverted, in the same cycle.
- R5: With the select for the active direction high, the driven port shows that direction's storage register. Changes on the live input have no effect.
- R6: The A-to-B register of a lane loads that lane's `a_in` at a `clk` edge where `stb_ab` is high and was low at the previous edge. At every other edge it holds.
- R7: The B-to-A register of a lane loads that lane's `b_in` at a `clk` edge where `stb_ba` is high and was low at the previous edge. At every other edge it holds.
- R8: Captures happen regardless of `oe_n`, `dir_ab` and the selects.
- R9: Each lane follows only its own controls. With identical controls on both lanes, the 16-bit ports behave as one 16-bit path.
- R10: The registers have no reset. While `rst_n` (synchronous, active low) is low, no capture occurs. A strobe that is already high when reset ends does not cause a capture until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low reset of strobe edge tracking |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data driven onto port A |
| a_oe | output | 16 | Per-bit drive enable of port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data driven onto port B |
| b_oe | output | 16 | Per-bit drive enable of port B |
| dir_ab | input | 2 | Per lane: 1 drives B from A, 0 drives A from B |
| oe_n | input | 2 | Per lane active-low output enable |
| sel_ab | input | 2 | Per lane: 1 sources B from the A-to-B register |
| sel_ba | input | 2 | Per lane: 1 sources A from the B-to-A register |
| stb_ab | input | 2 | Per lane capture strobe of the A-to-B register |
| stb_ba | input | 2 | Per lane capture strobe of the B-to-A register |

## Verification
A wrong register content stays hidden until the lane is enabled in stored mode for that direction. It then shows on the very next combinational read of the driven port. The bench therefore loads both registers early and switches often into stored mode.

A wrong edge-tracking state shows as a capture one strobe too early or too late. The next stored-mode read after that strobe exposes it. A routing or enable fault shows in the same cycle on the enable or value vectors.

// File: rtl/xcvr_pkg.sv
// Shared types for the dual-bus transceiver.
// Assumes: one control record per lane, all fields active high except oe_n.
package xcvr_pkg;

    typedef struct packed {
        logic dir_ab;   // 1: drive B from A, 0: drive A from B
        logic oe_n;     // active-low output enable
        logic sel_ab;   // 1: B sourced from A-to-B register
        logic sel_ba;   // 1: A sourced from B-to-A register
    } lane_ctrl_t;

endpackage

// File: rtl/lane_store.sv
// One direction's storage register with strobe rising-edge detection.
// Assumes: strobe is synchronous to clk; register content has no reset,
// only the edge tracker is reset (to "high" so a held strobe is not an edge).
module lane_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic strobe_q;
    logic load;

    // Capture qualifies only outside reset and on a low-to-high strobe.
    assign load = rst_n && strobe && !strobe_q;

    // Track the strobe level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= strobe;
        end
    end

    // Storage register: loads on a qualified edge, otherwise holds.
    always_ff @(posedge clk) begin
        if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lane_route.sv
// Combinational routing of one lane: picks the source and drives one side.
// Assumes: at most one port of the lane is enabled; released bits read zero.
module lane_route
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  lane_ctrl_t       ctrl,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] q_ab,
    input  logic [WIDTH-1:0] q_ba,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    logic drive_a;
    logic drive_b;
    logic [WIDTH-1:0] src_ab;
    logic [WIDTH-1:0] src_ba;

    // Decide which side of the lane is driven.
    always_comb begin
        drive_b = !ctrl.oe_n &&  ctrl.dir_ab;
        drive_a = !ctrl.oe_n && !ctrl.dir_ab;
    end

    // Choose live or stored data for each direction.
    always_comb begin
        src_ab = ctrl.sel_ab ? q_ab : a_in;
        src_ba = ctrl.sel_ba ? q_ba : b_in;
    end

    // Gate values and enables onto the ports.
    always_comb begin
        b_oe  = {WIDTH{drive_b}};
        a_oe  = {WIDTH{drive_a}};
        b_out = drive_b ? src_ab : '0;
        a_out = drive_a ? src_ba : '0;
    end

endmodule

// File: rtl/dual_bus_xcvr.sv
// Top: byte-lane registered bidirectional transceiver between ports A and B.
// Assumes: each lane has independent controls; strobes are sampled on clk.
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a_in,
    output logic [W-1:0]     a_out,
    output logic [W-1:0]     a_oe,
    input  logic [W-1:0]     b_in,
    output logic [W-1:0]     b_out,
    output logic [W-1:0]     b_oe,
    input  logic [LANES-1:0] dir_ab,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [LANES-1:0] stb_ab,
    input  logic [LANES-1:0] stb_ba
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_ctrl_t        ctrl;
        logic [LANE_W-1:0] q_ab;
        logic [LANE_W-1:0] q_ba;

        // Bundle this lane's control pins.
        always_comb begin
            ctrl.dir_ab = dir_ab[l];
            ctrl.oe_n   = oe_n[l];
            ctrl.sel_ab = sel_ab[l];
            ctrl.sel_ba = sel_ba[l];
        end

        lane_store #(.WIDTH(LANE_W)) u_st_ab (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_ab[l]),
            .d      (a_in[l*LANE_W +: LANE_W]),
            .q      (q_ab)
        );

        lane_store #(.WIDTH(LANE_W)) u_st_ba (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_ba[l]),
            .d      (b_in[l*LANE_W +: LANE_W]),
            .q      (q_ba)
        );

        lane_route #(.WIDTH(LANE_W)) u_route (
            .ctrl  (ctrl),
            .a_in  (a_in[l*LANE_W +: LANE_W]),
            .b_in  (b_in[l*LANE_W +: LANE_W]),
            .q_ab  (q_ab),
            .q_ba  (q_ba),
            .a_out (a_out[l*LANE_W +: LANE_W]),
            .a_oe  (a_oe[l*LANE_W +: LANE_W]),
            .b_out (b_out[l*LANE_W +: LANE_W]),
            .b_oe  (b_oe[l*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
// Checker for dual_bus_xcvr: port-level properties per lane.
// Assumes: keeps its own shadow of each register, valid only after a
// capture it has observed itself.
module dual_bus_xcvr_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     a_in,
    input logic [W-1:0]     a_out,
    input logic [W-1:0]     a_oe,
    input logic [W-1:0]     b_in,
    input logic [W-1:0]     b_out,
    input logic [W-1:0]     b_oe,
    input logic [LANES-1:0] dir_ab,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [LANES-1:0] stb_ab,
    input logic [LANES-1:0] stb_ba
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic              pv_ab, pv_ba, ok_ab, ok_ba;
        logic [LANE_W-1:0] sh_ab, sh_ba;
        logic [LANE_W-1:0] ai, bi, ao, bo, ae, be;

        assign ai = a_in[l*LANE_W +: LANE_W];
        assign bi = b_in[l*LANE_W +: LANE_W];
        assign ao = a_out[l*LANE_W +: LANE_W];
        assign bo = b_out[l*LANE_W +: LANE_W];
        assign ae = a_oe[l*LANE_W +: LANE_W];
        assign be = b_oe[l*LANE_W +: LANE_W];

        // Shadow strobe history and validity of shadow contents.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pv_ab <= 1'b1;
                pv_ba <= 1'b1;
                ok_ab <= 1'b0;
                ok_ba <= 1'b0;
            end else begin
                pv_ab <= stb_ab[l];
                pv_ba <= stb_ba[l];
                if (stb_ab[l] && !pv_ab) ok_ab <= 1'b1;
                if (stb_ba[l] && !pv_ba) ok_ba <= 1'b1;
            end
        end

        // Shadow copies of the two storage registers.
        always_ff @(posedge clk) begin
            if (rst_n && stb_ab[l] && !pv_ab) sh_ab <= ai;
            if (rst_n && stb_ba[l] && !pv_ba) sh_ba <= bi;
        end

        a_r1_b_side: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && dir_ab[l]) |-> (&be && ae == '0 && ao == '0));
        a_r2_a_side: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && !dir_ab[l]) |-> (&ae && be == '0 && bo == '0));
        a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[l] |-> (ae == '0 && be == '0 && ao == '0 && bo == '0));
        a_r4_live_ab: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && dir_ab[l] && !sel_ab[l]) |-> (bo == ai));
        a_r4_live_ba: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && !dir_ab[l] && !sel_ba[l]) |-> (ao == bi));
        a_r5_stored_ab: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && dir_ab[l] && sel_ab[l] && ok_ab) |-> (bo == sh_ab));
        a_r5_stored_ba: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[l] && !dir_ab[l] && sel_ba[l] && ok_ba) |-> (ao == sh_ba));
    end

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_dual_bus_xcvr.sv
module tb_dual_bus_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 2;
    localparam int LW = 8;
    localparam int W = LANES * LW;

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
    logic [LANES-1:0] dir_ab, oe_n, sel_ab, sel_ba, stb_ab, stb_ba;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    logic [LW-1:0] m_ab [LANES];
    logic [LW-1:0] m_ba [LANES];
    bit pv_ab [LANES];
    bit pv_ba [LANES];

    dual_bus_xcvr #(.LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .dir_ab(dir_ab), .oe_n(oe_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .stb_ab(stb_ab), .stb_ba(stb_ba)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model of capture at a clk edge (R6, R7, R10)
    task automatic model_edge();
        for (int l = 0; l < LANES; l++) begin
            if (!rst_n) begin
                pv_ab[l] = 1;
                pv_ba[l] = 1;
            end else begin
                if (stb_ab[l] && !pv_ab[l]) m_ab[l] = a_in[l*LW +: LW];
                if (stb_ba[l] && !pv_ba[l]) m_ba[l] = b_in[l*LW +: LW];
                pv_ab[l] = stb_ab[l];
                pv_ba[l] = stb_ba[l];
            end
        end
    endtask

    // Compare every lane against the model
    task automatic compare_all();
        for (int l = 0; l < LANES; l++) begin
            logic [LW-1:0] ea, eb, eao, ebo;
            bit db, da;
            string te, td;
            db = !oe_n[l] && dir_ab[l];
            da = !oe_n[l] && !dir_ab[l];
            ebo = {LW{db}};
            eao = {LW{da}};
            eb = db ? (sel_ab[l] ? m_ab[l] : a_in[l*LW +: LW]) : '0;
            ea = da ? (sel_ba[l] ? m_ba[l] : b_in[l*LW +: LW]) : '0;
            te = oe_n[l] ? "R3" : (dir_ab[l] ? "R1" : "R2");
            td = db ? (sel_ab[l] ? "R5" : "R4") : (da ? (sel_ba[l] ? "R5" : "R4") : "R3");
            check(te, W'({b_oe[l*LW +: LW], a_oe[l*LW +: LW]}), W'({ebo, eao}));
            check(td, W'({b_out[l*LW +: LW], a_out[l*LW +: LW]}), W'({eb, ea}));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; oe_n = '1; dir_ab = '0; sel_ab = '0; sel_ba = '0;
        stb_ab = '1; stb_ba = '1; a_in = '0; b_in = '0;
        for (int l = 0; l < LANES; l++) begin pv_ab[l] = 1; pv_ba[l] = 1; end
        repeat (3) tick();
        // Reset state, all disabled: R3, R10
        check("R3", a_oe | b_oe | a_out | b_out, '0);
        rst_n = 1;
        tick();
        // Load both registers with a clean strobe edge: R6, R7
        stb_ab = '0; stb_ba = '0;
        tick();
        a_in = 16'hC35A; b_in = 16'h9E17; stb_ab = '1; stb_ba = '1;
        tick();
        stb_ab = '0; stb_ba = '0; a_in = 16'h0000; b_in = 16'hFFFF;
        oe_n = '0; dir_ab = '1; sel_ab = '1;
        #1 check("R6", b_out, 16'hC35A);   // tied lanes act as 16 bits: R9
        dir_ab = '0; sel_ba = '1;
        #1 check("R7", a_out, 16'h9E17);
        tick();
        // Capture while disabled and facing the other way: R8
        oe_n = '1; a_in = 16'h1234; stb_ab = '1;
        tick();
        stb_ab = '0; oe_n = '0; dir_ab = '1; a_in = 16'h0F0F;
        #1 check("R8", b_out, 16'h1234);
        tick();
        // Strobe rises inside reset and stays high past release: R10
        rst_n = 0; stb_ab = '1; a_in = 16'hAAAA;
        repeat (2) tick();
        a_in = 16'h5555; rst_n = 1;
        repeat (2) tick();
        check("R10", b_out, 16'h1234);
        // Lanes with different controls: R9
        dir_ab = 2'b01; sel_ab = 2'b00; sel_ba = 2'b00; a_in = 16'h7788; b_in = 16'h3344;
        #1 check("R9", {b_out[15:8], a_out[7:0], b_out[7:0], a_out[15:8]},
                 {8'h00, 8'h00, 8'h88, 8'h33});
        tick();
        // Randomised traffic compared on every clock
        for (int i = 0; i < 4000; i++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            dir_ab = 2'($urandom); oe_n = 2'($urandom);
            sel_ab = 2'($urandom); sel_ba = 2'($urandom);
            stb_ab = 2'($urandom); stb_ba = 2'($urandom);
            if ($urandom % 2 == 0) begin
                dir_ab[1] = dir_ab[0]; oe_n[1] = oe_n[0];
                sel_ab[1] = sel_ab[0]; sel_ba[1] = sel_ba[0];
                stb_ab[1] = stb_ab[0]; stb_ba[1] = stb_ba[0];
            end
            rst_n = ($urandom % 200) != 0;
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule